// File: doc/BRIEF.md
# Prescaled Auto-Reload Time Base

This block produces periodic update events from the system clock. A programmable prescaler divides the clock by the programmed value plus one, and each divided tick advances an up-counter. When the counter reaches the programmed reload limit, it wraps to zero on the next tick and raises an update event. Software controls the block through a single-cycle register write port and observes it through a combinational read port. The outputs are a one-cycle update pulse, a sticky update flag, a level interrupt request and a one-cycle DMA request.

The prescaler always works from a shadow copy that reloads only on an update event. The reload limit can take effect at once, or it can wait in a shadow until the next update. A software strobe forces an update. The block can make overflow the only source that signals updates, suppress update events entirely, or stop itself after one period.

Register addresses (3-bit): 0 control, 1 status, 2 force, 3 counter, 4 prescaler, 5 reload. Control bits: 0 run, 1 update-suppress, 2 overflow-only signalling, 3 single-shot, 4 reload buffering, 5 interrupt enable, 6 DMA enable.

Top module: `tbase_timer`

## Requirements
- R1: After reset, every readable register (control, status, counter, prescaler, reload) reads 0, and `updPulse`, `irq` and `dmaReq` are 0.
- R2: With prescaler 0 and reload N, the counter counts up by one each cycle, wraps from N to 0 and signals an update every N+1 cycles.
- R3: With prescaler P, the counter advances once every P+1 cycles. A prescaler written at address 4 takes effect only at the next update event, so the period already under way keeps the old division.
- R4: A reload value written at address 5 takes effect immediately when control bit 4 is 0. When control bit 4 is 1, it takes effect only after the next update event.
- R5: Each signalled update sets the status flag (status bit 0). The flag stays set until a status write with bit 0 equal to 0 clears it. A status write with bit 0 equal to 1 has no effect.
- R6: `irq` equals the status flag AND control bit 5. `dmaReq` pulses for one cycle together with `updPulse` when control bit 6 is set, and is 0 otherwise.
- R7: A write of 1 in bit 0 to address 2 forces an update. The forced update clears the counter and the prescaler count, reloads the shadows and signals an update one cycle later.
- R8: With control bit 2 set, a forced update still clears the counter and reloads the shadows, but it sets no flag and produces no pulse. Overflow still signals.
- R9: With control bit 1 set, no update events occur. The counter still wraps, forced updates do nothing, and the flag stays unchanged.
- R10: With control bit 3 set, the run bit (control bit 0) clears itself at the update event, so the counter stops after one period.
- R11: While run is 0, the counter and prescaler count hold their values. A counter write at address 3 loads the counter directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | W | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | W | Read data (combinational) |
| updPulse | output | 1 | One-cycle signalled update event |
| updFlag | output | 1 | Sticky update flag |
| irq | output | 1 | Interrupt request level |
| dmaReq | output | 1 | One-cycle DMA request |

## Verification
The update pulse train is checked against exact gaps, starting from a forced update that sets a known phase. The stimulus covers an undivided clock with a short reload, a prescaler change in mid-period, and buffered and unbuffered reload changes in mid-period. The mid-period changes separate "effective now" from "effective at the next update": the first period after such a change keeps the old length only under deferral. Silent forced updates, suppressed updates and single-shot stops are told apart through the counter value read back and the presence or absence of pulses and flag changes.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 7;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_FORCE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd4;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd5;

  localparam int B_RUN     = 0;
  localparam int B_UPDDIS  = 1;
  localparam int B_OVFONLY = 2;
  localparam int B_ONESHOT = 3;
  localparam int B_ARPRE   = 4;
  localparam int B_IRQEN   = 5;
  localparam int B_DMAEN   = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic ldCnt;
    logic ldPsc;
    logic ldArr;
    logic arrDirect;
    logic uev;
    logic run;
  } strobeT;
endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTRL_W-1:0] wrLow,
  input  logic              ovf,
  output strobeT            strb,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic              flag,
  output logic              updPulse,
  output logic              dmaReq
);
  logic wrCtrl, wrStat, forceReq, uev, loud;

  assign wrCtrl   = wrEn && (wrAddr == A_CTRL);
  assign wrStat   = wrEn && (wrAddr == A_STAT);
  assign forceReq = wrEn && (wrAddr == A_FORCE) && wrLow[0];
  assign uev      = !ctrlReg[B_UPDDIS] && (ovf || forceReq);
  assign loud     = uev && (ovf || !ctrlReg[B_OVFONLY]);

  always_comb begin
    strb.ldCnt     = wrEn && (wrAddr == A_COUNT);
    strb.ldPsc     = wrEn && (wrAddr == A_PSC);
    strb.ldArr     = wrEn && (wrAddr == A_RELOAD);
    strb.arrDirect = !ctrlReg[B_ARPRE];
    strb.uev       = uev;
    strb.run       = ctrlReg[B_RUN];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      flag     <= 1'b0;
      updPulse <= 1'b0;
      dmaReq   <= 1'b0;
    end else begin
      if (wrCtrl)
        ctrlReg <= wrLow;
      else if (uev && ctrlReg[B_ONESHOT])
        ctrlReg[B_RUN] <= 1'b0;

      if (loud)
        flag <= 1'b1;
      else if (wrStat && !wrLow[0])
        flag <= 1'b0;

      updPulse <= loud;
      dmaReq   <= loud && ctrlReg[B_DMAEN];
    end
  end
endmodule

// File: rtl/tbase_dp.sv
module tbase_dp
  import tbase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobeT       strb,
  input  logic [W-1:0] wrData,
  output logic         ovf,
  output logic [W-1:0] cnt,
  output logic [W-1:0] pscPre,
  output logic [W-1:0] arrPre
);
  logic [W-1:0] pscCnt, pscSh, arrSh;
  logic         tick;

  assign tick = strb.run && (pscCnt == pscSh);
  assign ovf  = tick && (cnt == arrSh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      pscCnt <= '0;
      pscSh  <= '0;
      pscPre <= '0;
      arrSh  <= '0;
      arrPre <= '0;
    end else begin
      if (strb.ldPsc) pscPre <= wrData;
      if (strb.ldArr) arrPre <= wrData;

      if (strb.ldArr && strb.arrDirect) arrSh <= wrData;
      else if (strb.uev)                arrSh <= arrPre;

      if (strb.uev) pscSh <= pscPre;

      if (strb.uev)      pscCnt <= '0;
      else if (strb.run) pscCnt <= tick ? '0 : pscCnt + 1'b1;

      if (strb.ldCnt)   cnt <= wrData;
      else if (strb.uev) cnt <= '0;
      else if (tick)     cnt <= (cnt == arrSh) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [W-1:0]      wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [W-1:0]      rdData,
  output logic              updPulse,
  output logic              updFlag,
  output logic              irq,
  output logic              dmaReq
);
  strobeT            strb;
  logic [CTRL_W-1:0] ctrlReg;
  logic              ovf;
  logic [W-1:0]      cntVal, pscPre, arrPre;

  tbase_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrLow(wrData[CTRL_W-1:0]), .ovf(ovf), .strb(strb),
    .ctrlReg(ctrlReg), .flag(updFlag), .updPulse(updPulse), .dmaReq(dmaReq)
  );

  tbase_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .ovf(ovf), .cnt(cntVal), .pscPre(pscPre), .arrPre(arrPre)
  );

  assign irq = updFlag && ctrlReg[B_IRQEN];

  always_comb begin
    case (rdAddr)
      A_CTRL:   rdData = {{(W-CTRL_W){1'b0}}, ctrlReg};
      A_STAT:   rdData = {{(W-1){1'b0}}, updFlag};
      A_COUNT:  rdData = cntVal;
      A_PSC:    rdData = pscPre;
      A_RELOAD: rdData = arrPre;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         wrEn,
  input logic [2:0]   wrAddr,
  input logic         wrBit0,
  input logic         updPulse,
  input logic         flag,
  input logic         irq,
  input logic         dmaReq,
  input logic         run,
  input logic         updDis,
  input logic         oneShot,
  input logic [W-1:0] cnt
);
  // R5: flag only drops on a clearing status write
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !(wrEn && wrAddr == 3'd1 && !wrBit0)) |=> flag);

  // R6: interrupt only with flag set
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag);

  // R6: DMA request only alongside an update pulse
  a_r6_dma_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> updPulse);

  // R9: suppressed updates never pulse
  a_r9_no_pulse_when_dis: assert property (@(posedge clk) disable iff (!rstN)
    updDis |=> !updPulse);

  // R10: single-shot stops the counter at the update
  a_r10_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
    (updPulse && $past(oneShot) && !$past(wrEn)) |-> !run);

  // R11: stopped counter holds without writes
  a_r11_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !wrEn) |=> $stable(cnt));
endmodule

bind tbase_timer tbase_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrBit0(wrData[0]),
  .updPulse(updPulse), .flag(updFlag), .irq(irq), .dmaReq(dmaReq),
  .run(ctrlReg[0]), .updDis(ctrlReg[1]), .oneShot(ctrlReg[3]), .cnt(cntVal)
);

// File: tb/test_tbase_timer.sv
module test_tbase_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        updPulse, updFlag, irq, dmaReq;

  always #2.5 clk = ~clk;

  tbase_timer i_tbase_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .updPulse(updPulse), .updFlag(updFlag),
    .irq(irq), .dmaReq(dmaReq)
  );

  typedef struct {
    int    gap;
    bit    dma;
    string tag;
  } expT;

  expT q[$];
  int  vectors = 0;
  int  errors = 0;
  int  cyc = 0;
  int  lastCyc = 0;
  bit  done = 1'b0;

  always @(posedge clk) cyc++;

  // monitor: pops expected update events
  always @(negedge clk) begin
    if (rstN && updPulse) begin
      vectors++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected update pulse at cycle %0d: actual 1 expected 0", cyc);
      end else begin
        expT e;
        e = q.pop_front();
        if (e.gap != 0 && (cyc - lastCyc) != e.gap) begin
          errors++;
          $display("FAIL %s update gap actual %0d expected %0d", e.tag, cyc - lastCyc, e.gap);
        end
        if (dmaReq != e.dma) begin
          errors++;
          $display("FAIL R6 dmaReq actual %0b expected %0b", dmaReq, e.dma);
        end
      end
      lastCyc = cyc;
    end
  end

  task automatic push(int gap, bit dma, string tag);
    expT e;
    e.gap = gap; e.dma = dma; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rdChk(string tag, logic [2:0] a, logic [15:0] exp);
    rdAddr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) rdChk("R1", 3'(a), 16'h0);
    chk("R1 pulse", {15'h0, updPulse}, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 dma", {15'h0, dmaReq}, 16'h0);

    // R2, R7: undivided clock, reload 4
    wr(3'd5, 16'd4);
    wr(3'd0, 16'h01);
    push(0, 1'b0, "R7");
    wr(3'd2, 16'h1);
    push(5, 1'b0, "R2"); push(5, 1'b0, "R2");
    repeat (12) @(negedge clk);
    wr(3'd0, 16'h0);
    rdChk("R5 flag set", 3'd1, 16'h1);
    chk("R6 irq off", {15'h0, irq}, 16'h0);

    // R3: prescaler change deferred to next update
    wr(3'd3, 16'd0);
    wr(3'd5, 16'd3);
    wr(3'd0, 16'h41);
    push(0, 1'b1, "R7");
    wr(3'd2, 16'h1);
    @(negedge clk);
    wr(3'd4, 16'd2);
    push(4, 1'b1, "R3"); push(12, 1'b1, "R3"); push(12, 1'b1, "R3");
    repeat (30) @(negedge clk);
    wr(3'd0, 16'h0);

    // R4: buffered reload
    wr(3'd3, 16'd0);
    wr(3'd4, 16'd0);
    wr(3'd5, 16'd3);
    wr(3'd0, 16'h71);
    push(0, 1'b1, "R7");
    wr(3'd2, 16'h1);
    wr(3'd5, 16'd6);
    chk("R6 irq on", {15'h0, irq}, 16'h1);
    push(4, 1'b1, "R4"); push(7, 1'b1, "R4"); push(7, 1'b1, "R4");
    repeat (19) @(negedge clk);
    wr(3'd0, 16'h0);

    // R4: unbuffered reload
    wr(3'd3, 16'd0);
    wr(3'd0, 16'h41);
    wr(3'd5, 16'd3);
    push(0, 1'b1, "R7");
    wr(3'd2, 16'h1);
    wr(3'd5, 16'd5);
    push(6, 1'b1, "R4"); push(6, 1'b1, "R4");
    repeat (12) @(negedge clk);
    wr(3'd0, 16'h0);

    // R5, R6: flag and interrupt
    rdChk("R5 sticky", 3'd1, 16'h1);
    wr(3'd0, 16'h20);
    chk("R6 irq level", {15'h0, irq}, 16'h1);
    wr(3'd1, 16'h1);
    rdChk("R5 write one", 3'd1, 16'h1);
    wr(3'd1, 16'h0);
    rdChk("R5 cleared", 3'd1, 16'h0);
    chk("R6 irq cleared", {15'h0, irq}, 16'h0);
    wr(3'd0, 16'h0);

    // R8: silent forced update
    wr(3'd5, 16'd3);
    wr(3'd3, 16'd2);
    wr(3'd0, 16'h45);
    wr(3'd2, 16'h1);
    rdChk("R8 counter reloaded", 3'd3, 16'd0);
    rdChk("R8 no flag", 3'd1, 16'h0);
    push(0, 1'b1, "R8");
    repeat (6) @(negedge clk);
    rdChk("R8 overflow flags", 3'd1, 16'h1);
    wr(3'd0, 16'h0);

    // R9: suppressed updates
    wr(3'd1, 16'h0);
    wr(3'd3, 16'd0);
    wr(3'd0, 16'h03);
    repeat (9) @(negedge clk);
    rdChk("R9 wrap", 3'd3, 16'd1);
    wr(3'd2, 16'h1);
    rdChk("R9 force ignored", 3'd3, 16'd2);
    rdChk("R9 no flag", 3'd1, 16'h0);
    wr(3'd0, 16'h0);

    // R10: single shot
    push(0, 1'b0, "R7");
    wr(3'd2, 16'h1);
    wr(3'd0, 16'h49);
    push(5, 1'b1, "R10");
    repeat (8) @(negedge clk);
    rdChk("R10 run cleared", 3'd0, 16'h48);
    rdChk("R10 counter stopped", 3'd3, 16'd0);

    // R11: freeze and direct counter load
    wr(3'd3, 16'd2);
    repeat (5) @(negedge clk);
    rdChk("R11 frozen", 3'd3, 16'd2);
    wr(3'd4, 16'd7);
    rdChk("R3 prescaler readback", 3'd4, 16'd7);
    rdChk("R4 reload readback", 3'd5, 16'd3);

    repeat (4) @(negedge clk);
    chk("R2 all events seen", 16'(q.size()), 16'd0);
    finishRun();
  end
endmodule